// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block watches over a clock-frequency change. Software arms it through a small control word. Once armed, every frequency change that is accepted restarts a countdown. The countdown runs on one of two external tick sources, chosen by a prescale bit: a fine unit or a coarse unit. The real-time ticks are made outside the block. If the countdown runs out before software disarms the block, several things happen. A sticky expiry flag is set. A reset pulse can be issued. The block enters a recovery state, which tells the clock path to fall back to its recovery frequency and blocks any further frequency-change requests.

Recovery ends in one way only: software writes the arm bit to 0. That stops the countdown, reloads it and releases the lock. A second, independent enable asks for the same reset pulse after every accepted frequency change.

The reset request is active-low and is meant to drive an open-drain pull-down. Its length is a fixed number of fine ticks.

Top module: `fswd_guard`

## Requirements
- R1: After reset the control word reads 0x01F. The layout of `ctl_rdata` is: bits [4:0] time-out value, bit 5 coarse prescale, bit 6 arm, bit 7 reset-on-expiry, bit 8 reset-on-change, bit 9 expiry flag. The time-out value resets to all ones and every other bit resets to 0.
- R2: While the block is armed, an accepted frequency change loads the time-out value V and starts the countdown. Expiry happens on the (V+1)th selected tick, so V = 0 expires on the first tick.
- R3: With bit 5 at 0 only `tick_fine` advances the countdown. With bit 5 at 1 only `tick_coarse` advances it.
- R4: Expiry sets flag bit 9. A write with bit 9 at 1 clears the flag. A write with bit 9 at 0 leaves it unchanged. If expiry and a clearing write fall in the same cycle, the set wins.
- R5: Expiry drives `sys_rst_n` low only when bit 7 is 1.
- R6: When bit 8 is 1, every accepted frequency change drives `sys_rst_n` low, whether or not the block is armed.
- R7: `sys_rst_n` goes low in the cycle after its trigger. It returns high on the PULSE_TICKS-th `tick_fine` that follows.
- R8: From the cycle after expiry, `recovery_active` and `freq_write_lock` are 1. While they are 1, `freq_apply` stays 0 whatever `freq_change_req` does.
- R9: A write that clears arm bit 6 stops the countdown and releases recovery in the cycle after the write. While the block is disarmed, ticks have no effect.
- R10: An accepted frequency change during a countdown reloads the countdown from the time-out value.
- R11: While no lock is active, `freq_apply` follows `freq_change_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fine | input | 1 | One-cycle pulse per fine time unit |
| tick_coarse | input | 1 | One-cycle pulse per coarse time unit |
| freq_change_req | input | 1 | Request to change the output frequency |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 10 | Control word write data |
| ctl_rdata | output | 10 | Current control word and expiry flag |
| freq_apply | output | 1 | Frequency change accepted this cycle |
| recovery_active | output | 1 | Recovery frequency forced |
| freq_write_lock | output | 1 | Frequency-change requests are being ignored |
| sys_rst_n | output | 1 | Active-low reset request for an open-drain driver |

## Verification
The assertions assume three things about the inputs. Each tick input and each change request is a single-cycle pulse sampled on the clock. Control writes occur only in cycles chosen by the driver. No input changes value inside a cycle. The stimulus meets these assumptions by changing all inputs at the falling clock edge and holding them for exactly one cycle. Ticks, writes and change requests are kept in separate cycles, with one exception: the final step deliberately lines up a clearing write with the expiring tick.

// File: rtl/fswd_pkg.sv
package fswd_pkg;

    localparam int LIMIT_W     = 5;
    localparam int REG_W       = LIMIT_W + 5;
    localparam int BIT_COARSE  = LIMIT_W;
    localparam int BIT_ARM     = LIMIT_W + 1;
    localparam int BIT_RST_EXP = LIMIT_W + 2;
    localparam int BIT_RST_CHG = LIMIT_W + 3;
    localparam int BIT_FLAG    = LIMIT_W + 4;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_COUNT   = 2'd1,
        WD_RECOVER = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic               rst_on_change;
        logic               rst_on_expire;
        logic               arm;
        logic               coarse;
        logic [LIMIT_W-1:0] limit;
    } wd_cfg_t;

    function automatic wd_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        return wd_cfg_t'(w[REG_W-2:0]);
    endfunction

endpackage

// File: rtl/fswd_regs.sv
module fswd_regs
    import fswd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             expire_evt,
    output wd_cfg_t          cfg_q,
    output logic             arm_eff,
    output logic [REG_W-1:0] rdata
);

    wd_cfg_t cfg_w;
    logic    flag_q;

    assign cfg_w   = cfg_from_word(wdata);
    assign arm_eff = wr ? cfg_w.arm : cfg_q.arm;
    assign rdata   = {flag_q, cfg_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.limit         <= '1;
            cfg_q.coarse        <= 1'b0;
            cfg_q.arm           <= 1'b0;
            cfg_q.rst_on_expire <= 1'b0;
            cfg_q.rst_on_change <= 1'b0;
        end else if (wr) begin
            cfg_q <= cfg_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (expire_evt) begin
            flag_q <= 1'b1;
        end else if (wr && wdata[BIT_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/fswd_countdown.sv
module fswd_countdown
    import fswd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_eff,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               tick_sel,
    input  logic               chg_ok,
    output logic               locked,
    output logic               expire_evt
);

    wd_state_e          state_q;
    logic [LIMIT_W-1:0] cnt_q;

    assign locked     = (state_q == WD_RECOVER);
    assign expire_evt = arm_eff && (state_q == WD_COUNT) && !chg_ok
                        && tick_sel && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else if (!arm_eff) begin
            state_q <= WD_IDLE;
            cnt_q   <= limit;
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    if (chg_ok) begin
                        state_q <= WD_COUNT;
                        cnt_q   <= limit;
                    end
                end
                WD_COUNT: begin
                    if (chg_ok) begin
                        cnt_q <= limit;
                    end else if (tick_sel) begin
                        if (cnt_q == '0) begin
                            state_q <= WD_RECOVER;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                WD_RECOVER: begin
                    state_q <= WD_RECOVER;
                end
                default: begin
                    state_q <= WD_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fswd_pulse.sv
module fswd_pulse #(
    parameter int PULSE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    input  logic tick,
    output logic pulse_n
);

    localparam int PCW = $clog2(PULSE_TICKS + 1);

    logic [PCW-1:0] remain_q;

    assign pulse_n = (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (trigger) begin
            remain_q <= PCW'(PULSE_TICKS);
        end else if (tick && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

endmodule

// File: rtl/fswd_guard.sv
module fswd_guard
    import fswd_pkg::*;
#(
    parameter int PULSE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_fine,
    input  logic             tick_coarse,
    input  logic             freq_change_req,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    output logic             freq_apply,
    output logic             recovery_active,
    output logic             freq_write_lock,
    output logic             sys_rst_n
);

    wd_cfg_t cfg_q;
    logic    arm_eff;
    logic    locked;
    logic    expire_evt;
    logic    tick_sel;
    logic    pulse_trig;

    assign tick_sel   = cfg_q.coarse ? tick_coarse : tick_fine;
    assign freq_apply = freq_change_req && !locked;
    assign pulse_trig = (expire_evt && cfg_q.rst_on_expire)
                        || (freq_apply && cfg_q.rst_on_change);

    assign recovery_active = locked;
    assign freq_write_lock = locked;

    fswd_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (ctl_wr),
        .wdata      (ctl_wdata),
        .expire_evt (expire_evt),
        .cfg_q      (cfg_q),
        .arm_eff    (arm_eff),
        .rdata      (ctl_rdata)
    );

    fswd_countdown u_count (
        .clk        (clk),
        .rst        (rst),
        .arm_eff    (arm_eff),
        .limit      (cfg_q.limit),
        .tick_sel   (tick_sel),
        .chg_ok     (freq_apply),
        .locked     (locked),
        .expire_evt (expire_evt)
    );

    fswd_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trigger (pulse_trig),
        .tick    (tick_fine),
        .pulse_n (sys_rst_n)
    );

endmodule

// File: rtl/fswd_guard_chk.sv
module fswd_guard_chk
    import fswd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic [REG_W-1:0] ctl_wdata,
    input logic [REG_W-1:0] ctl_rdata,
    input logic             freq_apply,
    input logic             recovery_active,
    input logic             freq_write_lock,
    input logic             sys_rst_n,
    input logic             expire_evt
);

    // R8: expiry enters recovery and locks frequency requests
    p_expire_locks_r8: assert property (@(posedge clk) disable iff (rst)
        expire_evt |=> (recovery_active && freq_write_lock));

    // R4: expiry raises the flag
    p_expire_flags_r4: assert property (@(posedge clk) disable iff (rst)
        expire_evt |=> ctl_rdata[BIT_FLAG]);

    // R4: flag held unless a clearing write arrives
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[BIT_FLAG] && !(ctl_wr && ctl_wdata[BIT_FLAG])) |=> ctl_rdata[BIT_FLAG]);

    // R9: disarmed means no recovery on the following cycle
    p_disarm_release_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[BIT_ARM] |=> !recovery_active);

    // R5 / R6: reset only falls after an enabled cause
    p_rst_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_n) |->
            (($past(expire_evt) && $past(ctl_rdata[BIT_RST_EXP]))
             || ($past(freq_apply) && $past(ctl_rdata[BIT_RST_CHG]))));

    // R8: a locked block accepts no change
    p_locked_no_apply_r8: assert property (@(posedge clk) disable iff (rst)
        (recovery_active && $past(recovery_active)) |-> !freq_apply);

endmodule

bind fswd_guard fswd_guard_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .ctl_wr          (ctl_wr),
    .ctl_wdata       (ctl_wdata),
    .ctl_rdata       (ctl_rdata),
    .freq_apply      (freq_apply),
    .recovery_active (recovery_active),
    .freq_write_lock (freq_write_lock),
    .sys_rst_n       (sys_rst_n),
    .expire_evt      (expire_evt)
);

// File: tb/fswd_guard_bench.sv
module fswd_guard_bench;

    localparam int PERIOD = 10;
    localparam int PT     = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_fine = 1'b0;
    logic       tick_coarse = 1'b0;
    logic       freq_change_req = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [9:0] ctl_wdata = '0;
    logic [9:0] ctl_rdata;
    logic       freq_apply;
    logic       recovery_active;
    logic       freq_write_lock;
    logic       sys_rst_n;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        string       req;
        logic [13:0] exp;
    } exp_t;

    exp_t sb_q[$];

    always #(PERIOD/2) clk = ~clk;

    fswd_guard #(.PULSE_TICKS(PT)) u_fswd_guard (
        .clk             (clk),
        .rst             (rst),
        .tick_fine       (tick_fine),
        .tick_coarse     (tick_coarse),
        .freq_change_req (freq_change_req),
        .ctl_wr          (ctl_wr),
        .ctl_wdata       (ctl_wdata),
        .ctl_rdata       (ctl_rdata),
        .freq_apply      (freq_apply),
        .recovery_active (recovery_active),
        .freq_write_lock (freq_write_lock),
        .sys_rst_n       (sys_rst_n)
    );

    function automatic logic [13:0] ev(input logic [9:0] rd, input logic rn,
                                       input logic rec, input logic ap);
        return {rd, rn, rec, rec, ap};
    endfunction

    // Driver: one cycle of stimulus, expected state after the next rising edge
    task automatic step(input logic f, input logic c, input logic ch,
                        input logic w, input logic [9:0] wd,
                        input string req, input logic [13:0] ex);
        @(negedge clk);
        tick_fine       = f;
        tick_coarse     = c;
        freq_change_req = ch;
        ctl_wr          = w;
        ctl_wdata       = wd;
        sb_q.push_back('{req, ex});
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [13:0] obs;
                it  = sb_q.pop_front();
                obs = {ctl_rdata, sys_rst_n, recovery_active, freq_write_lock, freq_apply};
                n_checks++;
                if (obs !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: got=%h exp=%h", it.req, obs, it.exp);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 defaults
        step(0,0,0,0,10'h000, "R1 reset state", ev(10'h01F,1,0,0));
        // arm, fine units, value 2, reset on expiry
        step(0,0,0,1,10'h0C2, "R1 write readback", ev(10'h0C2,1,0,0));
        step(0,0,1,0,10'h000, "R11 change accepted", ev(10'h0C2,1,0,1));
        step(1,0,0,0,10'h000, "R2 first tick", ev(10'h0C2,1,0,0));
        step(0,1,0,0,10'h000, "R3 coarse ignored", ev(10'h0C2,1,0,0));
        step(1,0,0,0,10'h000, "R2 second tick", ev(10'h0C2,1,0,0));
        step(1,0,0,0,10'h000, "R2 R5 expiry on third tick", ev(10'h2C2,0,1,0));
        step(0,0,1,0,10'h000, "R8 change blocked", ev(10'h2C2,0,1,0));
        step(1,0,0,0,10'h000, "R7 pulse tick 1", ev(10'h2C2,0,1,0));
        step(1,0,0,0,10'h000, "R7 pulse tick 2", ev(10'h2C2,0,1,0));
        step(1,0,0,0,10'h000, "R7 pulse ends", ev(10'h2C2,1,1,0));
        step(0,0,0,1,10'h0C2, "R4 write 0 keeps flag", ev(10'h2C2,1,1,0));
        step(0,0,0,1,10'h2C2, "R4 write 1 clears flag", ev(10'h0C2,1,1,0));
        step(0,0,0,1,10'h082, "R9 disarm releases", ev(10'h082,1,0,0));
        step(0,0,1,0,10'h000, "R11 change while disarmed", ev(10'h082,1,0,1));
        for (int i = 0; i < 3; i++)
            step(1,0,0,0,10'h000, "R9 ticks while disarmed", ev(10'h082,1,0,0));
        // value 0, coarse units, arm, reset on change only
        step(0,0,0,1,10'h160, "R1 write readback 2", ev(10'h160,1,0,0));
        step(0,0,1,0,10'h000, "R6 change pulse", ev(10'h160,0,0,1));
        step(1,0,0,0,10'h000, "R3 fine ignored in coarse", ev(10'h160,0,0,0));
        step(1,0,0,0,10'h000, "R7 pulse holds", ev(10'h160,0,0,0));
        step(1,0,0,0,10'h000, "R7 pulse ends", ev(10'h160,1,0,0));
        step(0,1,0,0,10'h000, "R2 R5 zero value no pulse", ev(10'h360,1,1,0));
        step(0,0,0,1,10'h120, "R9 disarm keeps flag", ev(10'h320,1,0,0));
        // value 1, fine units, arm, no resets, clear flag
        step(0,0,0,1,10'h241, "R4 clear flag", ev(10'h041,1,0,0));
        step(0,0,1,0,10'h000, "R2 start", ev(10'h041,1,0,1));
        step(1,0,0,0,10'h000, "R2 count", ev(10'h041,1,0,0));
        step(0,0,1,0,10'h000, "R10 reload", ev(10'h041,1,0,1));
        step(1,0,0,0,10'h000, "R10 no early expiry", ev(10'h041,1,0,0));
        step(1,0,0,1,10'h241, "R4 set wins over clear", ev(10'h241,1,1,0));
        step(0,0,0,0,10'h000, "R8 lock holds", ev(10'h241,1,1,0));
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule